// File: doc/BRIEF.md
# Reset and Power-Mode Supervisor

This block sits beside a small 8-bit controller core and decides when the core runs, sleeps or is held in reset. It runs from the raw oscillator clock. A toggle flop halves that clock, and every clock enable the block produces is a single-cycle pulse on alternate oscillator edges, so the duty cycle of the incoming clock plays no part. A free-running phase counter marks the end of each machine cycle, which is 12 oscillator periods. The reset pin is filtered against those machine-cycle marks: a core reset is issued only when the pin has stayed high for two complete machine cycles, and the reset is released on a machine-cycle boundary.

Software asks for one of two low-power states through single-cycle request strobes. In idle, the CPU clock enable stops while the peripheral clock enable keeps pulsing. Idle ends on any enabled interrupt or on the reset pin. In power-down, the oscillator-run output falls and both enables stop. Only the reset pin can end power-down. The pin restarts the oscillator at once, without waiting for a clock edge, and the CPU stays frozen until the filtered reset takes hold. When idle is ended by the reset pin, the CPU runs for a short window before the core reset lands. A RAM write-block output covers that window and the reset itself, so the RAM contents survive while the special registers are reinitialised.

Top module: `rst_pwr_ctl`

## Requirements
- R1: `core_rst` rises only on a machine-cycle boundary after `rst_pin` has been sampled high without a break. Counting from the first oscillator edge that sees the pin high, the rise falls on edge 26 to 37. A single low sample restarts the count, so a 20-cycle high pulse never causes a reset.
- R2: After `rst_pin` goes low, `core_rst` falls on a machine-cycle boundary, on edge 2 to 13 after the first edge that sees the pin low.
- R3: Outside idle and power-down, `cpu_clk_en` and `periph_clk_en` are single-cycle pulses on alternate oscillator cycles. Any 20 consecutive cycles hold exactly 10 pulses, and no two pulses are adjacent.
- R4: After a one-cycle `req_idle` strobe, `cpu_clk_en` stays 0 while `periph_clk_en` keeps its alternate-cycle pulses and `osc_run` stays 1.
- R5: In idle, `irq_pend` high for one cycle ends idle, and `cpu_clk_en` pulses again within 3 cycles. `ram_wr_block` stays 0 after this kind of wake.
- R6: In idle, a rise of `rst_pin` ends idle once the pin is synchronised (2 edges), so `cpu_clk_en` pulses before `core_rst` rises. `ram_wr_block` is 1 from the third cycle after the pin rises until `core_rst` asserts.
- R7: After a one-cycle `req_pd` strobe, `osc_run`, `cpu_clk_en` and `periph_clk_en` are all 0 from the next cycle. `irq_pend` does not change this.
- R8: In power-down, a rise of `rst_pin` sets `osc_run` to 1 with no clock edge. Both enables stay 0 until `core_rst` is 1, and `core_rst` then follows the R1 window. Both enables pulse during the core reset.
- R9: When `req_idle` and `req_pd` arrive in the same cycle, power-down wins.
- R10: Requests are ignored while `core_rst` is 1 or while the synchronised pin is high. After release, the CPU runs normally.
- R11: `ram_wr_block` is 1 while `core_rst` is 1 and 0 in normal run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| req_idle | input | 1 | One-cycle strobe from software asking for idle |
| req_pd | input | 1 | One-cycle strobe from software asking for power-down |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| core_rst | output | 1 | Synchronous reset to the core, aligned to machine cycles |
| cpu_clk_en | output | 1 | CPU clock enable pulse (half rate) |
| periph_clk_en | output | 1 | Timer, serial, interrupt and RAM clock enable pulse (half rate) |
| osc_run | output | 1 | Oscillator enable; 0 in power-down |
| ram_wr_block | output | 1 | Blocks internal RAM writes |

## Verification
The bench measures the distance from the pin edge to the reset edge against the R1 and R2 windows. A filter that counted partial machine cycles would fire too early, and one that did not restart on a short low sample would fire off two glitches. It wakes power-down with the clock running but the block frozen, and checks that the oscillator restarts without an edge. A design that cleared power-down synchronously would stay asleep forever. It also checks that the CPU does not slip out of reset early. Idle is ended both by interrupt and by the pin, and in the pin case the bench checks that the RAM write block covers the short window in which the CPU still runs. It also issues both requests in one cycle, where a wrong priority would leave the oscillator running.

// File: rtl/rst_pwr_ctl.sv
module rst_pwr_ctl #(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2
) (
  input  logic clk_osc,
  input  logic rst_pin,
  input  logic req_idle,
  input  logic req_pd,
  input  logic irq_pend,
  output logic core_rst,
  output logic cpu_clk_en,
  output logic periph_clk_en,
  output logic osc_run,
  output logic ram_wr_block
);

  localparam int TICKS_PER_MC = OSC_PER_MC / 2;
  localparam int ST_W = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(TICKS_PER_MC - 1);
  localparam int HC_W = $clog2(HOLD_MC + 1);
  localparam logic [HC_W-1:0] HC_FULL = HC_W'(HOLD_MC);
  localparam int MIN_HI = HOLD_MC * OSC_PER_MC;
  localparam int RUN_W = $clog2(MIN_HI + 1) + 1;

  logic            half;
  logic [ST_W-1:0] st;
  logic            sync1, pin_s;
  logic [HC_W-1:0] hcnt;
  logic            pd_q, pd_hold, idle_q, rst_wake;
  logic            mstb, run;

  assign osc_run       = ~pd_q;
  assign mstb          = half && (st == ST_LAST);
  assign run           = ~idle_q & ~pd_hold & ~core_rst & ~pin_s;
  assign cpu_clk_en    = osc_run & half & ~idle_q & ~pd_hold;
  assign periph_clk_en = osc_run & half & ~pd_hold;
  assign ram_wr_block  = rst_wake | core_rst;

  // divide-by-two and machine-cycle phase
  always_ff @(posedge clk_osc) begin
    if (osc_run) begin
      half <= ~half;
      if (half) st <= (st == ST_LAST) ? '0 : st + 1'b1;
    end
  end

  // pin synchroniser and hold filter
  always_ff @(posedge clk_osc) begin
    if (osc_run) begin
      sync1 <= rst_pin;
      pin_s <= sync1;
      if (!pin_s)                      hcnt <= '0;
      else if (mstb && hcnt != HC_FULL) hcnt <= hcnt + 1'b1;
      if (mstb) core_rst <= pin_s && (hcnt == HC_FULL);
    end
  end

  // oscillator stop, cleared by the pin without a clock
  always_ff @(posedge clk_osc or posedge rst_pin) begin
    if (rst_pin)             pd_q <= 1'b0;
    else if (run && req_pd)  pd_q <= 1'b1;
  end

  always_ff @(posedge clk_osc) begin
    if (osc_run) begin
      if (core_rst)                 pd_hold <= 1'b0;
      else if (run && req_pd)       pd_hold <= 1'b1;

      if (core_rst)                           idle_q <= 1'b0;
      else if (idle_q && (irq_pend || pin_s)) idle_q <= 1'b0;
      else if (run && req_idle && !req_pd)    idle_q <= 1'b1;

      if (core_rst || !pin_s)       rst_wake <= 1'b0;
      else if (idle_q)              rst_wake <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  logic [RUN_W-1:0] pin_hi_run;
  always_ff @(posedge clk_osc) begin
    if (!rst_pin)         pin_hi_run <= '0;
    else if (~&pin_hi_run) pin_hi_run <= pin_hi_run + 1'b1;
    // R1: reset only after the pin held high for the full hold time
    if (osc_run && mstb && pin_s && hcnt == HC_FULL && !core_rst)
      a_r1_hold_time: assert (pin_hi_run >= RUN_W'(MIN_HI))
        else $error("R1 reset asserted after %0d high cycles", pin_hi_run);
  end

  a_r3_half_rate: assert property (@(posedge clk_osc) disable iff (!osc_run)
    cpu_clk_en |=> !cpu_clk_en);

  a_r5_irq_wake: assert property (@(posedge clk_osc) disable iff (rst_pin)
    (osc_run && idle_q && irq_pend && !core_rst) |=> !idle_q);

  a_r6_ram_block: assert property (@(posedge clk_osc) disable iff (core_rst)
    (osc_run && idle_q && pin_s) |=> ram_wr_block);

  a_r7_pd_sticky: assert property (@(posedge clk_osc) disable iff (rst_pin)
    !osc_run |=> !osc_run);

  a_r9_pd_priority: assert property (@(posedge clk_osc) disable iff (rst_pin)
    (osc_run && run && req_pd && req_idle) |=> (!osc_run && !cpu_clk_en));

endmodule

// File: tb/rst_pwr_ctl_tb.sv
module rst_pwr_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_pin, req_idle, req_pd, irq_pend;
  logic core_rst, cpu_clk_en, periph_clk_en, osc_run, ram_wr_block;

  always #2 clk = ~clk;

  rst_pwr_ctl dut_i (
    .clk_osc(clk), .rst_pin(rst_pin), .req_idle(req_idle), .req_pd(req_pd),
    .irq_pend(irq_pend), .core_rst(core_rst), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_run(osc_run), .ram_wr_block(ram_wr_block));

  localparam int MC = 12, HOLD = 2;
  localparam int RISE_MIN = 3 + HOLD * MC, RISE_MAX = 2 + MC + HOLD * MC;
  localparam int FALL_MIN = 3, FALL_MAX = 2 + MC;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  // raise pin and return cycles until core_rst seen
  task automatic pin_up(output int k);
    rst_pin = 1'b1; k = 0;
    do begin cyc(); k++; end while (!core_rst && k < 80);
  endtask

  task automatic pin_down(output int k);
    rst_pin = 1'b0; k = 0;
    do begin cyc(); k++; end while (core_rst && k < 80);
  endtask

  task automatic count_cpu(input int n, output int cnt, output bit adj);
    bit prev = 0; cnt = 0; adj = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (cpu_clk_en) cnt++;
      if (cpu_clk_en && prev) adj = 1;
      prev = cpu_clk_en;
    end
  endtask

  task automatic pulse(input bit idl, input bit pd);
    req_idle = idl; req_pd = pd; cyc(); req_idle = 0; req_pd = 0;
  endtask

  task automatic t_first_reset();
    int k, c; bit a;
    pin_up(k);
    chk(k >= RISE_MIN && k <= RISE_MAX, "R1 first reset rise cycle", k, RISE_MIN);
    chk(osc_run == 1, "R11 reset state osc_run", osc_run, 1);
    chk(ram_wr_block == 1, "R11 ram blocked in reset", ram_wr_block, 1);
    count_cpu(20, c, a);
    chk(c == 10, "R8 clocks run during reset", c, 10);
    pin_down(k);
    chk(k >= FALL_MIN && k <= FALL_MAX, "R2 release cycle", k, FALL_MIN);
    chk(ram_wr_block == 0, "R11 ram free in run", ram_wr_block, 0);
  endtask

  task automatic t_rate();
    int c; bit a;
    count_cpu(20, c, a);
    chk(c == 10, "R3 pulses in 20 cycles", c, 10);
    chk(!a, "R3 no adjacent pulses", a, 0);
  endtask

  task automatic t_glitch();
    int k, seen = 0;
    rst_pin = 1;
    for (int i = 0; i < 20; i++) begin cyc(); if (core_rst) seen++; end
    rst_pin = 0;
    for (int i = 0; i < 20; i++) begin cyc(); if (core_rst) seen++; end
    chk(seen == 0, "R1 short pulse ignored", seen, 0);
    rst_pin = 1;
    for (int i = 0; i < 20; i++) cyc();
    rst_pin = 0;
    for (int i = 0; i < 4; i++) cyc();
    pin_up(k);
    chk(k >= RISE_MIN && k <= RISE_MAX, "R1 count restarts after low", k, RISE_MIN);
    pin_down(k);
    chk(k >= FALL_MIN && k <= FALL_MAX, "R2 release after restart", k, FALL_MIN);
  endtask

  task automatic t_idle_irq();
    int c = 0, p = 0, o = 1;
    pulse(1, 0);
    for (int i = 0; i < 30; i++) begin
      cyc(); if (cpu_clk_en) c++; if (periph_clk_en) p++; if (!osc_run) o = 0;
    end
    chk(c == 0, "R4 cpu stopped in idle", c, 0);
    chk(p == 15, "R4 peripheral pulses in idle", p, 15);
    chk(o == 1, "R4 oscillator runs in idle", o, 1);
    irq_pend = 1; cyc(); irq_pend = 0;
    c = 0;
    for (int i = 0; i < 3; i++) begin cyc(); if (cpu_clk_en) c++; end
    chk(c >= 1, "R5 irq ends idle", c, 1);
    chk(ram_wr_block == 0, "R5 no ram block after irq wake", ram_wr_block, 0);
  endtask

  task automatic t_idle_pin();
    int k = 0, c = 0, bad = 0;
    pulse(1, 0);
    for (int i = 0; i < 10; i++) cyc();
    rst_pin = 1;
    do begin
      cyc(); k++;
      if (!core_rst && cpu_clk_en) c++;
      if (k >= 3 && !ram_wr_block) bad++;
    end while (!core_rst && k < 80);
    chk(c > 0, "R6 cpu runs before reset lands", c, 1);
    chk(bad == 0, "R6 ram blocked during window", bad, 0);
    chk(k >= RISE_MIN && k <= RISE_MAX, "R6 reset after idle wake", k, RISE_MIN);
    pin_down(k);
  endtask

  task automatic t_pd();
    int k = 0, woke = 0, early = 0, c; bit a;
    pulse(0, 1);
    chk(osc_run == 0 && cpu_clk_en == 0 && periph_clk_en == 0,
        "R7 all stopped in power-down", osc_run, 0);
    irq_pend = 1;
    for (int i = 0; i < 30; i++) begin cyc(); if (osc_run) woke++; end
    irq_pend = 0;
    chk(woke == 0, "R7 irq ignored in power-down", woke, 0);
    rst_pin = 1; #1;
    chk(osc_run == 1, "R8 pin restarts oscillator without edge", osc_run, 1);
    do begin
      cyc(); k++;
      if (!core_rst && (cpu_clk_en || periph_clk_en)) early++;
    end while (!core_rst && k < 80);
    chk(early == 0, "R8 enables frozen before reset", early, 0);
    chk(k >= RISE_MIN && k <= RISE_MAX, "R8 reset window after wake", k, RISE_MIN);
    count_cpu(10, c, a);
    chk(c >= 4, "R8 clocks run in reset after wake", c, 5);
    pin_down(k);
  endtask

  task automatic t_priority();
    int k;
    pulse(1, 1);
    chk(osc_run == 0, "R9 power-down wins", osc_run, 0);
    pin_up(k);
    pin_down(k);
  endtask

  task automatic t_ignored();
    int k, c; bit a;
    rst_pin = 1;
    for (int i = 0; i < 5; i++) cyc();
    pulse(1, 0);
    count_cpu(10, c, a);
    chk(c == 5, "R10 idle request ignored while pin high", c, 5);
    while (!core_rst) cyc();
    pulse(1, 1);
    chk(osc_run == 1, "R10 requests ignored in reset", osc_run, 1);
    pin_down(k);
    count_cpu(20, c, a);
    chk(c == 10 && osc_run, "R10 normal run after release", c, 10);
  endtask

  initial begin
    rst_pin = 1; req_idle = 0; req_pd = 0; irq_pend = 0;
    rst_pin = 0; cyc(); cyc();
    t_first_reset();
    t_rate();
    t_glitch();
    t_idle_irq();
    t_idle_pin();
    t_pd();
    t_priority();
    t_ignored();
    t_rate();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule